// File: doc/BRIEF.md
# Host interrupt controller with peek and take status views

This block collects up to sixteen event lines from device logic and turns each rising edge into a sticky pending bit. A per-bit block mask decides which pending bits may raise the single level-type interrupt line towards the host. The line's polarity can be selected, and the line can be switched off entirely.

The host reaches the block over a simple synchronous register bus with a write strobe, a read strobe and a 3-bit register selector. It can load the block mask whole or change it bit by bit. Two aliases do this: one sets the bits written as 1 and one clears them, and bits written as 0 are left alone. Pending bits can be read in two ways. A peek read leaves them untouched. A take read returns them and empties the whole set in the same step. An acknowledge register retires chosen bits one by one. Pending bits latch whatever the mask holds, so a driver may poll masked events and may unmask an event that is already waiting.

Register selector codes: 0 block mask (read/write), 1 mask set (write only), 2 mask clear (write only), 3 peek status (read only), 4 take status (read only), 5 acknowledge (write only), 6 line configuration (read/write; bit 0 enable, bit 1 active-low), 7 unused. Implemented event lines are 0 to 10 and 14. Lines 11, 12, 13 and 15 are reserved.

Top module: `hirq_ctrl`

## Requirements
- R1: After reset the block mask reads 0x0001, both status views read 0, the configuration reads 0x1 (enabled, active-high) and the interrupt line is low.
- R2: A rising edge on an implemented event line (bits 0-10 and 14) sets its pending bit on the next clock edge. A line held high does not set the bit again after it has been cleared. Edges on reserved lines 11, 12, 13 and 15 never set a pending bit.
- R3: A write to selector 0 loads bits 15:0 of the write data into the block mask. Reads of selector 0 return the mask with bits 31:16 as zero. A mask bit of 1 keeps its pending bit from raising the line.
- R4: A write to selector 1 sets each mask bit written as 1 and leaves the others unchanged.
- R5: A write to selector 2 clears each mask bit written as 1 and leaves the others unchanged.
- R6: A read of selector 3 returns the pending bits in bits 15:0 and changes no state.
- R7: A read of selector 4 returns the pending bits as they stood before the read, and clears every pending bit on that same clock edge.
- R8: A write to selector 5 clears each pending bit written as 1, as seen through both views. Bits written as 0 are left unchanged.
- R9: If a rising edge and a clear (take read or acknowledge) reach the same pending bit on one clock edge, the bit is set afterwards.
- R10: With the line enabled, it is active exactly when some pending bit has a mask bit of 0. Clearing the mask bit of an already pending event activates the line right after the write edge.
- R11: Configuration bit 0 at 0 holds the line at its inactive level. Configuration bit 1 at 1 makes the line active-low (active = 0, inactive = 1).
- R12: Read data updates on the clock edge that samples the read strobe and holds until the next read. Reads of selectors 1, 2, 5 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register selector |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| src | input | 16 | Event lines from device logic |
| irq | output | 1 | Host interrupt line |

## Verification
The bench builds the block with its default parameters: sixteen event lines, a 32-bit data bus, the implemented-line map with four reserved bits, a reset mask of 0x0001 and a combinational line driver. The reserved bits in the map let the bench show that edges on lines 11 to 13 and 15 are dropped. Because the reset mask blocks line 0, the first pulse on that line shows a pending but blocked event. The gap between the 16-bit status and the 32-bit bus shows that the upper mask bits read back as zero. With the combinational driver, mask and configuration writes show on the line in the cycle right after the write edge, which is where the bench's cycle-by-cycle model expects them.

// File: rtl/hirq_pkg.sv
package hirq_pkg;

   typedef enum logic [2:0] {
      RA_MASK = 3'd0,
      RA_MSET = 3'd1,
      RA_MCLR = 3'd2,
      RA_PEEK = 3'd3,
      RA_TAKE = 3'd4,
      RA_ACK  = 3'd5,
      RA_CFG  = 3'd6,
      RA_NONE = 3'd7
   } hirq_addr_e;

   localparam int CFG_W       = 2;
   localparam int CFG_EN_BIT  = 0;
   localparam int CFG_LOW_BIT = 1;

   // level presented on the line for a given pending state and configuration
   function automatic logic hirq_level(input logic pend, input logic en, input logic low);
      return en ? (pend ^ low) : low;
   endfunction

endpackage

// File: rtl/hirq_status.sv
module hirq_status #(
   parameter int              NSRC     = 16,
   parameter logic [NSRC-1:0] SRC_IMPL = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] stat
);

   logic [NSRC-1:0] src_q;
   logic [NSRC-1:0] rise;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src;
   end

   assign rise = src & ~src_q;

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      if (SRC_IMPL[i]) begin : g_live
         // edge wins over a clear arriving on the same edge
         always_ff @(posedge clk) begin
            if (!rst_n) stat[i] <= 1'b0;
            else        stat[i] <= (stat[i] & ~clr[i]) | rise[i];
         end
      end else begin : g_resv
         logic unused_bit;
         assign unused_bit = rise[i] ^ clr[i];
         assign stat[i]    = 1'b0;
      end
   end

endmodule

// File: rtl/hirq_regs.sv
module hirq_regs
   import hirq_pkg::*;
#(
   parameter int               NSRC     = 16,
   parameter int               DW       = 32,
   parameter logic [NSRC-1:0]  MASK_RST = 16'h0001,
   parameter logic [CFG_W-1:0] CFG_RST  = 2'b01
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [2:0]       addr,
   input  logic [DW-1:0]    wdata,
   input  logic [NSRC-1:0]  stat,
   output logic [NSRC-1:0]  mask,
   output logic [CFG_W-1:0] cfg,
   output logic [NSRC-1:0]  clr,
   output logic [DW-1:0]    rdata
);

   localparam int PAD_S = DW - NSRC;
   localparam int PAD_C = DW - CFG_W;

   hirq_addr_e      sel;
   logic [NSRC-1:0] wlo;
   logic [DW-1:0]   rd_mux;
   logic            unused_wd;

   assign sel       = hirq_addr_e'(addr);
   assign wlo       = wdata[NSRC-1:0];
   assign unused_wd = ^wdata[DW-1:NSRC];

   // clear request towards the status bank
   always_comb begin
      clr = '0;
      if (rd_en && sel == RA_TAKE) clr = '1;
      if (wr_en && sel == RA_ACK)  clr = clr | wlo;
   end

   always_comb begin
      case (sel)
         RA_MASK: rd_mux = {{PAD_S{1'b0}}, mask};
         RA_PEEK: rd_mux = {{PAD_S{1'b0}}, stat};
         RA_TAKE: rd_mux = {{PAD_S{1'b0}}, stat};
         RA_CFG:  rd_mux = {{PAD_C{1'b0}}, cfg};
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask  <= MASK_RST;
         cfg   <= CFG_RST;
         rdata <= '0;
      end else begin
         if (wr_en) begin
            case (sel)
               RA_MASK: mask <= wlo;
               RA_MSET: mask <= mask | wlo;
               RA_MCLR: mask <= mask & ~wlo;
               RA_CFG:  cfg  <= wdata[CFG_W-1:0];
               default: ;
            endcase
         end
         if (rd_en) rdata <= rd_mux;
      end
   end

endmodule

// File: rtl/hirq_drive.sv
module hirq_drive
   import hirq_pkg::*;
#(
   parameter int   NSRC     = 16,
   parameter bit   REG_OUT  = 1'b0,
   parameter logic IDLE_RST = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] stat,
   input  logic [NSRC-1:0] mask,
   input  logic            en,
   input  logic            low,
   output logic            irq
);

   logic pend;
   logic lvl;

   assign pend = |(stat & ~mask);
   assign lvl  = hirq_level(pend, en, low);

   if (REG_OUT) begin : g_flop
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= IDLE_RST;
         else        irq <= lvl;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq        = lvl;
   end

endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
   import hirq_pkg::*;
#(
   parameter int               NSRC     = 16,
   parameter int               DW       = 32,
   parameter logic [NSRC-1:0]  SRC_IMPL = 16'h47FF,
   parameter logic [NSRC-1:0]  MASK_RST = 16'h0001,
   parameter logic [CFG_W-1:0] CFG_RST  = 2'b01,
   parameter bit               REG_OUT  = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            rd_en,
   input  logic [2:0]      addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   input  logic [NSRC-1:0] src,
   output logic            irq
);

   if (NSRC < 2 || NSRC >= DW) begin : g_bad_width
      $error("hirq_ctrl: NSRC must be at least 2 and below DW");
   end
   if (SRC_IMPL == '0) begin : g_bad_map
      $error("hirq_ctrl: SRC_IMPL selects no event line");
   end

   logic [NSRC-1:0]  stat_q;
   logic [NSRC-1:0]  mask_q;
   logic [NSRC-1:0]  clr_v;
   logic [CFG_W-1:0] cfg_q;

   hirq_status #(
      .NSRC     (NSRC),
      .SRC_IMPL (SRC_IMPL)
   ) u_status (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src),
      .clr   (clr_v),
      .stat  (stat_q)
   );

   hirq_regs #(
      .NSRC     (NSRC),
      .DW       (DW),
      .MASK_RST (MASK_RST),
      .CFG_RST  (CFG_RST)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .stat  (stat_q),
      .mask  (mask_q),
      .cfg   (cfg_q),
      .clr   (clr_v),
      .rdata (rdata)
   );

   hirq_drive #(
      .NSRC     (NSRC),
      .REG_OUT  (REG_OUT),
      .IDLE_RST (CFG_RST[CFG_LOW_BIT])
   ) u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .stat  (stat_q),
      .mask  (mask_q),
      .en    (cfg_q[CFG_EN_BIT]),
      .low   (cfg_q[CFG_LOW_BIT]),
      .irq   (irq)
   );

endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk
   import hirq_pkg::*;
#(
   parameter int              NSRC     = 16,
   parameter int              DW       = 32,
   parameter logic [NSRC-1:0] SRC_IMPL = 16'h47FF
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic            rd_en,
   input logic [2:0]      addr,
   input logic [DW-1:0]   wdata,
   input logic [DW-1:0]   rdata,
   input logic [NSRC-1:0] src,
   input logic [NSRC-1:0] stat,
   input logic [NSRC-1:0] mask
);

   logic [NSRC-1:0] src_d;
   logic [NSRC-1:0] edge_c;
   logic            unused_wd;

   assign unused_wd = ^wdata[DW-1:NSRC];

   always_ff @(posedge clk) begin
      if (!rst_n) src_d <= '0;
      else        src_d <= src;
   end

   assign edge_c = src & ~src_d & SRC_IMPL;

   // R7
   take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == RA_TAKE && edge_c == '0) |=> (stat == '0));

   // R6
   peek_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && addr == RA_PEEK && !wr_en && edge_c == '0) |=> (stat == $past(stat)));

   // R4
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_MSET) |=>
         ((mask & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

   // R5
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_MCLR) |=> ((mask & $past(wdata[NSRC-1:0])) == '0));

   // R9
   edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_c != '0) |=> ((stat & $past(edge_c)) == $past(edge_c)));

   // R3
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == RA_MASK) |=> (mask == $past(wdata[NSRC-1:0])));

   // R12
   wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == RA_MSET || addr == RA_MCLR || addr == RA_ACK || addr == RA_NONE))
         |=> (rdata == '0));

   // R6
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (addr == RA_PEEK || addr == RA_TAKE)) |=>
         (rdata[NSRC-1:0] == $past(stat)));

endmodule

bind hirq_ctrl hirq_ctrl_chk #(
   .NSRC     (NSRC),
   .DW       (DW),
   .SRC_IMPL (SRC_IMPL)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .rd_en (rd_en),
   .addr  (addr),
   .wdata (wdata),
   .rdata (rdata),
   .src   (src),
   .stat  (stat_q),
   .mask  (mask_q)
);

// File: tb/hirq_ctrl_test.sv
`timescale 1ns/1ps
module hirq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [31:0] wdata = 32'd0;
   logic [31:0] rdata;
   logic [15:0] src = 16'd0;
   logic        irq;

   integer n_cmp = 0;
   integer n_bad = 0;
   bit     done  = 1'b0;

   always #2 clk = ~clk;

   hirq_ctrl uut (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .rd_en (rd_en),
      .addr  (addr),
      .wdata (wdata),
      .rdata (rdata),
      .src   (src),
      .irq   (irq)
   );

   // behavioural reference, built from the requirements
   localparam logic [15:0] LIVE = 16'h47FF;
   logic [15:0] m_mask, m_stat, m_src_d, m_rise, m_clr;
   logic [1:0]  m_cfg;
   logic [31:0] m_rdata, m_rv;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mask = 16'h0001; m_stat = 16'h0; m_cfg = 2'b01;
         m_rdata = 32'h0; m_src_d = 16'h0;
      end else begin
         m_rise = src & ~m_src_d & LIVE;
         m_clr  = 16'h0;
         if (rd_en && addr == 3'd4) m_clr = 16'hFFFF;
         if (wr_en && addr == 3'd5) m_clr = m_clr | wdata[15:0];
         case (addr)
            3'd0:    m_rv = {16'h0, m_mask};
            3'd3:    m_rv = {16'h0, m_stat};
            3'd4:    m_rv = {16'h0, m_stat};
            3'd6:    m_rv = {30'h0, m_cfg};
            default: m_rv = 32'h0;
         endcase
         if (rd_en) m_rdata = m_rv;
         if (wr_en) begin
            case (addr)
               3'd0: m_mask = wdata[15:0];
               3'd1: m_mask = m_mask | wdata[15:0];
               3'd2: m_mask = m_mask & ~wdata[15:0];
               3'd6: m_cfg  = wdata[1:0];
               default: ;
            endcase
         end
         m_stat  = (m_stat & ~m_clr) | m_rise;
         m_src_d = src;
      end
   end

   function automatic logic exp_irq();
      logic pend;
      pend = (m_stat & ~m_mask) != 16'h0;
      if (!m_cfg[0]) return m_cfg[1];
      return m_cfg[1] ? !pend : pend;
   endfunction

   // comparison on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp = n_cmp + 2;
         if (irq !== exp_irq()) begin
            n_bad = n_bad + 1;
            $display("FAIL R10 irq act=%0b exp=%0b at %0t", irq, exp_irq(), $time);
         end
         if (rdata !== m_rdata) begin
            n_bad = n_bad + 1;
            $display("FAIL R12 rdata act=%h exp=%h at %0t", rdata, m_rdata, $time);
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp = n_cmp + 1;
      if (act !== exp) begin
         n_bad = n_bad + 1;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic w, input logic r, input logic [2:0] a,
                      input logic [31:0] d, input logic [15:0] s);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; wdata = d; src = s;
   endtask

   task automatic wr_op(input logic [2:0] a, input logic [31:0] d);
      cyc(1'b1, 1'b0, a, d, src);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, src);
   endtask

   task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
      cyc(1'b0, 1'b1, a, 32'h0, src);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, src);
      chk(tag, rdata, exp);
   endtask

   task automatic pulse(input logic [15:0] s);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, s);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 irq", {31'h0, irq}, 32'h0);
      rd_chk(3'd0, 32'h0001, "R1 mask");
      rd_chk(3'd3, 32'h0000, "R1 peek");
      rd_chk(3'd6, 32'h0001, "R1 cfg");
      // R2 edge latching, R6 non-destructive read
      pulse(16'h0002);
      rd_chk(3'd3, 32'h0002, "R2 edge bit1");
      rd_chk(3'd3, 32'h0002, "R6 peek repeat");
      chk("R10 line on", {31'h0, irq}, 32'h1);
      pulse(16'h0001);
      rd_chk(3'd3, 32'h0003, "R2 edge bit0");
      // R8 acknowledge
      wr_op(3'd5, 32'h0000_0002);
      rd_chk(3'd3, 32'h0001, "R8 ack bit1");
      chk("R10 masked pending", {31'h0, irq}, 32'h0);
      // R5 mask clear, R10 unmask pending
      wr_op(3'd2, 32'h0000_0001);
      rd_chk(3'd0, 32'h0000, "R5 mask clear");
      chk("R10 unmask", {31'h0, irq}, 32'h1);
      // R4 mask set
      wr_op(3'd1, 32'h0000_0081);
      rd_chk(3'd0, 32'h0081, "R4 mask set");
      chk("R3 blocked", {31'h0, irq}, 32'h0);
      // R7 take read
      rd_chk(3'd4, 32'h0001, "R7 take value");
      rd_chk(3'd3, 32'h0000, "R7 emptied");
      // R2 reserved lines
      pulse(16'hB800);
      rd_chk(3'd3, 32'h0000, "R2 reserved");
      // R2 held level does not re-set
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0008);
      rd_chk(3'd3, 32'h0008, "R2 held set");
      wr_op(3'd5, 32'h0000_0008);
      rd_chk(3'd3, 32'h0000, "R2 held no reset");
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0);
      // R9 edge beats acknowledge
      pulse(16'h0010);
      cyc(1'b1, 1'b0, 3'd5, 32'h0000_0010, 16'h0010);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0);
      rd_chk(3'd3, 32'h0010, "R9 edge vs ack");
      // R9 edge beats take read
      cyc(1'b0, 1'b1, 3'd4, 32'h0, 16'h0020);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0020);
      chk("R7 take old value", rdata, 32'h0010);
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0);
      rd_chk(3'd3, 32'h0020, "R9 edge vs take");
      // R3 full mask load, upper bits read zero
      wr_op(3'd0, 32'hFFFF_1234);
      rd_chk(3'd0, 32'h0000_1234, "R3 mask load");
      chk("R3 bit5 blocked", {31'h0, irq}, 32'h0);
      // R12 write-only selectors read zero
      rd_chk(3'd1, 32'h0, "R12 sel1");
      rd_chk(3'd2, 32'h0, "R12 sel2");
      rd_chk(3'd5, 32'h0, "R12 sel5");
      rd_chk(3'd7, 32'h0, "R12 sel7");
      // R11 line configuration
      wr_op(3'd0, 32'h0);
      chk("R10 pending unmasked", {31'h0, irq}, 32'h1);
      wr_op(3'd6, 32'h0);
      chk("R11 disabled", {31'h0, irq}, 32'h0);
      wr_op(3'd6, 32'h3);
      chk("R11 active-low asserted", {31'h0, irq}, 32'h0);
      rd_chk(3'd4, 32'h0020, "R7 take before idle");
      chk("R11 active-low idle", {31'h0, irq}, 32'h1);
      wr_op(3'd6, 32'h1);
      // mixed traffic against the reference model
      for (int i = 0; i < 3000; i++) begin
         logic [15:0] s;
         s = src ^ (16'($urandom) & 16'($urandom) & 16'($urandom));
         cyc(($urandom % 3) == 0, ($urandom % 3) == 0, 3'($urandom), $urandom, s);
      end
      cyc(1'b0, 1'b0, 3'd0, 32'h0, 16'h0);
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done  = 1'b1;
         n_cmp = n_cmp + 1;
         n_bad = n_bad + 1;
         $display("FAIL watchdog act=running exp=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule